// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 16-bit logical address from a processor core into a 20-bit physical address for a 1-megabyte memory. The logical space is cut into four zones on 4 KB granules. The lowest zone, called the root, always maps to itself. Each of the other three zones has an 8-bit relocation value. That value is added to the top nibble of the logical address, so the zone becomes a window onto any 4 KB-aligned region of physical memory.

Two of the three zone boundaries can be moved. Both come from one packed 8-bit size register. The boundary into the top zone is fixed at logical nibble 0xE. A small write port loads the size register and the three relocation registers. A bypass input lets an access that already carries a full 20-bit address skip translation. The translation path is combinational, and register writes take effect on the next clock edge.

Top module: `seg_xlat_unit`

## Requirements
- R1: When bypass is low, phys_addr[11:0] always equals log_addr[11:0].
- R2: When bypass is low, phys_addr[19:12] equals ({4'b0, log_addr[15:12]} + S) modulo 256, where S is the relocation value of the selected zone. Any carry out of bit 19 is dropped, so the address wraps within 1 MB.
- R3: The size register holds two boundaries: LO = bits [3:0] and HI = bits [7:4]. Let N = log_addr[15:12]. Zones are tested in ascending order, and the first match wins: N < LO selects root; otherwise N < HI selects zone A; otherwise N < 0xE selects zone B; otherwise zone C is selected.
- R4: The root zone maps to the identity, so phys_addr = {4'b0, log_addr}.
- R5: When LO equals HI, zone A is empty. When a boundary exceeds the one above it, the lower zone keeps precedence, following the ascending order of R3. This covers HI above 0xE, where zone A extends past nibble 0xE.
- R6: Register writes use cfg_we with cfg_sel: 0 = size register, 1 = zone A relocation, 2 = zone B relocation, 3 = zone C relocation. The data comes from cfg_wdata. A write changes phys_addr only after the next rising clock edge and leaves the unselected registers unchanged.
- R7: When bypass_en is high, phys_addr equals bypass_addr regardless of log_addr and the register contents.
- R8: Synchronous active-high reset clears every register, so after reset every logical address maps one-to-one into the lowest 64 KB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 size, 1 zone A, 2 zone B, 3 zone C |
| cfg_wdata | input | 8 | Register write data |
| log_addr | input | 16 | Logical address from the core |
| bypass_en | input | 1 | Pass bypass_addr straight through |
| bypass_addr | input | 20 | Full physical address used during bypass |
| phys_addr | output | 20 | Translated or bypassed physical address |

## Verification
The register assertions assume that reset is high at the first clock edge and that cfg_we, cfg_sel and cfg_wdata are never unknown. The bench therefore holds reset from time zero and drives every configuration input to a defined value before releasing it. The assertion for the top zone only applies when both boundaries are at or below 0xE; in that case the top zone is reached only from nibble 0xE upwards. The stimulus includes configurations on both sides of that condition, so the property is exercised without being required outside its scope. All inputs change on the falling edge, and the combinational output is sampled one nanosecond later.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  typedef enum logic [1:0] {
    ZONE_ROOT = 2'd0,
    ZONE_A    = 2'd1,
    ZONE_B    = 2'd2,
    ZONE_C    = 2'd3
  } zone_e;

  localparam logic [1:0] CFG_SIZE  = 2'd0;
  localparam logic [1:0] CFG_SEG_A = 2'd1;
  localparam logic [1:0] CFG_SEG_B = 2'd2;
  localparam logic [1:0] CFG_SEG_C = 2'd3;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W   = 8,
  parameter int BND_W   = 4,
  parameter int NUM_SEG = 3,
  parameter int SEL_W   = $clog2(NUM_SEG + 1)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [SEL_W-1:0]                cfg_sel,
  input  logic [SEG_W-1:0]                cfg_wdata,
  output logic [BND_W-1:0]                bnd_lo,
  output logic [BND_W-1:0]                bnd_hi,
  output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_q
);

  localparam int SIZE_W = 2 * BND_W;

  logic [SIZE_W-1:0] size_q;

  // size register: low field is the lower boundary, high field the upper
  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
    end else if (cfg_we && cfg_sel == SEL_W'(0)) begin
      size_q <= cfg_wdata[SIZE_W-1:0];
    end
  end

  assign bnd_lo = size_q[BND_W-1:0];
  assign bnd_hi = size_q[SIZE_W-1:BND_W];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        seg_q[g] <= '0;
      end else if (cfg_we && cfg_sel == SEL_W'(g + 1)) begin
        seg_q[g] <= cfg_wdata;
      end
    end

    // R6: a selected write lands one edge later
    p_seg_write_r6: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_sel == SEL_W'(g + 1)) |=> (seg_q[g] == $past(cfg_wdata)));

    // R6: an unselected register keeps its value
    p_seg_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !(cfg_we && cfg_sel == SEL_W'(g + 1)) |=> $stable(seg_q[g]));
  end

  // R6: size register written only when selected
  p_size_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_sel == SEL_W'(0)) |=> $stable(size_q));

  // R8: reset clears every register
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (size_q == '0 && seg_q == '0));

endmodule

// File: rtl/seg_zone_decode.sv
module seg_zone_decode
  import seg_xlat_pkg::*;
#(
  parameter int              NIB_W   = 4,
  parameter logic [NIB_W-1:0] TOP_NIB = 4'hE
) (
  input  logic [NIB_W-1:0] nib,
  input  logic [NIB_W-1:0] bnd_lo,
  input  logic [NIB_W-1:0] bnd_hi,
  output zone_e            zone
);

  // ascending test: the first boundary the nibble sits below wins
  always_comb begin
    if (nib < bnd_lo) begin
      zone = ZONE_ROOT;
    end else if (nib < bnd_hi) begin
      zone = ZONE_A;
    end else if (nib < TOP_NIB) begin
      zone = ZONE_B;
    end else begin
      zone = ZONE_C;
    end
  end

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int LA_W  = 16,
  parameter int OFF_W = 12,
  parameter int SEG_W = 8
) (
  input  logic [LA_W-1:0]        log_addr,
  input  logic [SEG_W-1:0]       seg,
  output logic [SEG_W+OFF_W-1:0] phys
);

  localparam int NIB_W = LA_W - OFF_W;

  logic [SEG_W-1:0] nib_ext;
  logic [SEG_W-1:0] hi_sum;

  assign nib_ext = {{(SEG_W - NIB_W){1'b0}}, log_addr[LA_W-1:OFF_W]};
  assign hi_sum  = nib_ext + seg;   // carry past the top bit is dropped
  assign phys    = {hi_sum, log_addr[OFF_W-1:0]};

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
  import seg_xlat_pkg::*;
#(
  parameter int LA_W    = 16,
  parameter int OFF_W   = 12,
  parameter int SEG_W   = 8,
  parameter int PA_W    = SEG_W + OFF_W,
  parameter int NUM_SEG = 3,
  parameter int SEL_W   = $clog2(NUM_SEG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [SEG_W-1:0] cfg_wdata,
  input  logic [LA_W-1:0]  log_addr,
  input  logic             bypass_en,
  input  logic [PA_W-1:0]  bypass_addr,
  output logic [PA_W-1:0]  phys_addr
);

  localparam int               NIB_W   = LA_W - OFF_W;
  localparam logic [NIB_W-1:0] TOP_NIB = NIB_W'(14);

  logic [NIB_W-1:0]              bnd_lo;
  logic [NIB_W-1:0]              bnd_hi;
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [NIB_W-1:0]              nib;
  zone_e                         zone;
  logic [SEG_W-1:0]              seg_pick;
  logic [PA_W-1:0]               xlat;

  assign nib = log_addr[LA_W-1:OFF_W];

  seg_regfile #(
    .SEG_W  (SEG_W),
    .BND_W  (NIB_W),
    .NUM_SEG(NUM_SEG),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .bnd_lo   (bnd_lo),
    .bnd_hi   (bnd_hi),
    .seg_q    (seg_q)
  );

  seg_zone_decode #(
    .NIB_W  (NIB_W),
    .TOP_NIB(TOP_NIB)
  ) u_decode (
    .nib   (nib),
    .bnd_lo(bnd_lo),
    .bnd_hi(bnd_hi),
    .zone  (zone)
  );

  always_comb begin
    case (zone)
      ZONE_A:  seg_pick = seg_q[0];
      ZONE_B:  seg_pick = seg_q[1];
      ZONE_C:  seg_pick = seg_q[NUM_SEG-1];
      default: seg_pick = '0;   // root: identity
    endcase
  end

  seg_adder #(
    .LA_W (LA_W),
    .OFF_W(OFF_W),
    .SEG_W(SEG_W)
  ) u_add (
    .log_addr(log_addr),
    .seg     (seg_pick),
    .phys    (xlat)
  );

  assign phys_addr = bypass_en ? bypass_addr : xlat;

  // R1: page offset passes through
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (rst)
    !bypass_en |-> (phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]));

  // R4: below the lower boundary the mapping is the identity
  p_root_ident_r4: assert property (@(posedge clk) disable iff (rst)
    (!bypass_en && nib < bnd_lo) |-> (phys_addr == PA_W'(log_addr)));

  // R3: with both boundaries at or under the fixed one, the top granules use zone C
  p_top_zone_r3: assert property (@(posedge clk) disable iff (rst)
    (!bypass_en && nib >= TOP_NIB && bnd_lo <= TOP_NIB && bnd_hi <= TOP_NIB)
      |-> (phys_addr[PA_W-1:OFF_W] == SEG_W'(SEG_W'(nib) + seg_q[NUM_SEG-1])));

  // R7: bypass drives the supplied address
  p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
    bypass_en |-> (phys_addr == bypass_addr));

endmodule

// File: tb/seg_xlat_unit_tb.sv
`timescale 1ns/1ps
module seg_xlat_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [15:0] log_addr = 16'd0;
  logic        bypass_en = 1'b0;
  logic [19:0] bypass_addr = 20'd0;
  logic [19:0] phys_addr;

  int n_checks = 0;
  int n_fail = 0;

  // model state
  logic [3:0] m_lo = 4'd0, m_hi = 4'd0;
  logic [7:0] m_sa = 8'd0, m_sb = 8'd0, m_sc = 8'd0;

  always #2.5 clk = ~clk;

  seg_xlat_unit u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .log_addr(log_addr), .bypass_en(bypass_en),
    .bypass_addr(bypass_addr), .phys_addr(phys_addr)
  );

  function automatic logic [19:0] model(input logic [15:0] a);
    logic [3:0] n;
    logic [7:0] s;
    logic [7:0] hi;
    n = a[15:12];
    if (n < m_lo) s = 8'd0;
    else if (n < m_hi) s = m_sa;
    else if (n < 4'hE) s = m_sb;
    else s = m_sc;
    hi = {4'd0, n} + s;
    return {hi, a[11:0]};
  endfunction

  task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %05h expected %05h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: begin m_lo = data[3:0]; m_hi = data[7:4]; end
      2'd1: m_sa = data;
      2'd2: m_sb = data;
      default: m_sc = data;
    endcase
  endtask

  task automatic sweep(input string tag);
    logic [11:0] offs [3];
    offs[0] = 12'h000; offs[1] = 12'h5A3; offs[2] = 12'hFFF;
    for (int n = 0; n < 16; n++) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        log_addr = {4'(n), offs[k]};
        #1;
        check(tag, phys_addr, model(log_addr));
        check("R1", {8'd0, phys_addr[11:0]}, {8'd0, log_addr[11:0]});
      end
    end
  endtask

  task automatic load(input logic [7:0] size, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] c);
    cfg_write(2'd0, size);
    cfg_write(2'd1, a);
    cfg_write(2'd2, b);
    cfg_write(2'd3, c);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: identity after reset
    sweep("R8");
    // R4: root spans everything below LO
    load(8'hA6, 8'h10, 8'h20, 8'h30);
    sweep("R4");
    // R2/R3 ordinary ordering with distinct offsets
    load(8'h84, 8'h3C, 8'h77, 8'hF0);
    sweep("R3");
    // R2 wrap past 1 MB
    load(8'h52, 8'hFF, 8'hF8, 8'hFE);
    sweep("R2");
    // R5 equal boundaries: zone A empty
    load(8'h66, 8'h11, 8'h22, 8'h33);
    sweep("R5");
    // R5 lower boundary above upper
    load(8'h39, 8'h44, 8'h55, 8'h66);
    sweep("R5");
    // R5 upper boundary beyond fixed one
    load(8'hF2, 8'h09, 8'h0A, 8'h0B);
    sweep("R5");
    // R5 lower boundary at top: root covers up to 0xE
    load(8'h0F, 8'h81, 8'h82, 8'h83);
    sweep("R5");
    // R3 zero boundaries: zone B from nibble 0
    load(8'h00, 8'hC0, 8'hD0, 8'hE0);
    sweep("R3");

    // R6 write timing: old mapping until the edge, new after
    load(8'hE2, 8'h01, 8'h02, 8'h03);
    @(negedge clk);
    log_addr = 16'h3123;
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'h70;
    #1;
    check("R6", phys_addr, model(log_addr));
    @(negedge clk);
    cfg_we = 1'b0;
    m_sa = 8'h70;
    #1;
    check("R6", phys_addr, 20'h73123);
    // R6 unselected registers intact
    sweep("R6");

    // R7 bypass over several patterns
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      bypass_en = 1'b1;
      bypass_addr = 20'(i * 20'h11111 + 20'h0F00F);
      log_addr = 16'(i * 16'h1357);
      #1;
      check("R7", phys_addr, bypass_addr);
    end
    @(negedge clk);
    bypass_en = 1'b0;
    log_addr = 16'hE456;
    #1;
    check("R7", phys_addr, model(log_addr));

    // R8 reset again restores identity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_lo = 4'd0; m_hi = 4'd0; m_sa = 8'd0; m_sb = 8'd0; m_sc = 8'd0;
    sweep("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule